// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a page table with two levels that sits in word-addressed memory. A requester hands over one virtual address together with the current root table base. The walker then issues two dependent reads on a simple read port.

The first read fetches the base of the second-level table. The second read fetches the leaf entry. The walk ends in one of two ways. It may return the physical address together with the leaf's access bits. Or it may report a fault with a two-bit cause.

The walker takes one translation at a time. Memory may answer after any number of cycles. The walker advances only when read data is marked valid.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `resp_valid` and `mem_req` are 0.
- R2: The first read goes to `root_base + 4 * vaddr[31:22]`. For example, root 0x00080000 with virtual address 0x00403004 reads 0x00080004.
- R3: The virtual address and root base are captured in the accepting cycle. Changes to `req_vaddr` or `root_base` while a walk is in progress do not affect its result.
- R4: A first-level word of zero ends the walk with `resp_fault`=1 and `resp_cause`=2'b01. No second read is issued.
- R5: When the first-level word is non-zero, the second read goes to that word plus `4 * vaddr[21:12]`.
- R6: A leaf entry whose present bit (bit 0) is 0 ends the walk with `resp_fault`=1 and `resp_cause`=2'b10.
- R7: On a present leaf, `resp_paddr` = {leaf[31:12], vaddr[11:0]}, with `resp_fault`=0 and `resp_cause`=2'b00.
- R8: On success, `resp_rw` equals leaf bit 1 and `resp_us` equals leaf bit 2. On any fault, both are 0.
- R9: Timing of the handshake and result:
  - `req_ready` is 0 from the cycle after acceptance until the result appears.
  - `resp_valid` is a single-cycle pulse.
  - `req_ready` is 1 in the same cycle as `resp_valid`, so a waiting request is accepted in that cycle.
- R10: While a read is outstanding, `mem_req` stays 1 and `mem_addr` stays unchanged until `mem_rvalid` is seen, whatever the latency.
- R11: A `mem_rvalid` pulse that arrives while no read is outstanding has no effect. No result is produced, `req_ready` stays 1, and the next walk is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of first-level table |
| mem_req | output | 1 | Read request, held until read data valid |
| mem_addr | output | 32 | Byte address of the word read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 2 | 00 none, 01 no second-level table, 10 page not present |
| resp_rw | output | 1 | Leaf read/write bit |
| resp_us | output | 1 | Leaf user/supervisor bit |

## Verification
Two events can meet in one cycle: delivering the result of one walk and accepting the next request. The bench provokes this by holding `req_valid` high through a whole walk and replacing the address while the walker is busy. It then checks three things:
- the first result matches the first address;
- the new address was taken in the strobe cycle;
- the second result follows without a lost or repeated request.

Memory latency is varied between tests. A stray read-valid pulse while the walker is idle is also tested.

// File: rtl/pt_walk_pkg.sv
// Package: shared state encoding, fault causes and leaf bit positions for
// the page table walker. Assumes 32-bit entries with the frame number on top.
package pt_walk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2
    } walk_state_t;

    localparam logic [1:0] CAUSE_NONE        = 2'b00;
    localparam logic [1:0] CAUSE_NO_TABLE    = 2'b01;
    localparam logic [1:0] CAUSE_NOT_PRESENT = 2'b10;

    localparam int PRESENT_BIT = 0;
    localparam int RW_BIT      = 1;
    localparam int US_BIT      = 2;
endpackage

// File: rtl/pt_addr_gen.sv
// Address generator: splits the captured virtual address into two table
// indices and an offset, and forms the byte address of the current read.
// Assumes entries of 2**ENTRY_SHIFT bytes and byte-addressed bases.
module pt_addr_gen #(
    parameter int VA_W        = 32,
    parameter int L1_BITS     = 10,
    parameter int L2_BITS     = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [VA_W-1:0]     vaddr,
    input  logic [VA_W-1:0]     root,
    input  logic [VA_W-1:0]     l1_word,
    input  logic                sel_l2,
    output logic [VA_W-1:0]     rd_addr,
    output logic [VA_W-L1_BITS-L2_BITS-1:0] offset
);
    localparam int OFF_BITS = VA_W - L1_BITS - L2_BITS;
    localparam int L1_LSB   = OFF_BITS + L2_BITS;

    logic [L1_BITS-1:0] idx1;
    logic [L2_BITS-1:0] idx2;
    logic [VA_W-1:0]    scaled1;
    logic [VA_W-1:0]    scaled2;

    // Purpose: slice the index fields and scale them to byte offsets.
    always_comb begin
        idx1    = vaddr[VA_W-1:L1_LSB];
        idx2    = vaddr[L1_LSB-1:OFF_BITS];
        offset  = vaddr[OFF_BITS-1:0];
        scaled1 = {{(VA_W-L1_BITS-ENTRY_SHIFT){1'b0}}, idx1, {ENTRY_SHIFT{1'b0}}};
        scaled2 = {{(VA_W-L2_BITS-ENTRY_SHIFT){1'b0}}, idx2, {ENTRY_SHIFT{1'b0}}};
    end

    // Purpose: pick the table base and index for the level being read.
    always_comb begin
        rd_addr = sel_l2 ? (l1_word + scaled2) : (root + scaled1);
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk controller: accepts one request when idle, captures its operands,
// and sequences the two dependent reads. Each read is held until read
// valid. A zero first-level word or any leaf read ends the walk.
// Read valid is ignored while idle.
module pt_walk_ctrl
    import pt_walk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] root_base,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            req_ready,
    output logic            mem_req,
    output logic            sel_l2,
    output logic [VA_W-1:0] vaddr_q,
    output logic [VA_W-1:0] root_q,
    output logic [VA_W-1:0] l1_q,
    output logic            ev_no_table,
    output logic            ev_leaf
);
    walk_state_t state;

    // Purpose: decode handshake outputs and end-of-walk events from state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_req     = (state == ST_L1) || (state == ST_L2);
        sel_l2      = (state == ST_L2);
        ev_no_table = (state == ST_L1) && mem_rvalid && (mem_rdata == '0);
        ev_leaf     = (state == ST_L2) && mem_rvalid;
    end

    // Purpose: walk state and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vaddr_q <= '0;
            root_q  <= '0;
            l1_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        root_q  <= root_base;
                        state   <= ST_L1;
                    end
                end
                ST_L1: begin
                    if (mem_rvalid) begin
                        if (mem_rdata == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            l1_q  <= mem_rdata;
                            state <= ST_L2;
                        end
                    end
                end
                ST_L2: begin
                    if (mem_rvalid) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_resp_reg.sv
// Result register: turns end-of-walk events into a one-cycle strobe that
// carries the physical address, access bits or a fault cause. Assumes at
// most one event per cycle and the leaf word valid with its event.
module pt_resp_reg
    import pt_walk_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int OFF_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_no_table,
    input  logic                ev_leaf,
    input  logic [VA_W-1:0]     leaf_word,
    input  logic [OFF_BITS-1:0] offset,
    output logic                resp_valid,
    output logic [VA_W-1:0]     resp_paddr,
    output logic                resp_fault,
    output logic [1:0]          resp_cause,
    output logic                resp_rw,
    output logic                resp_us
);
    // Purpose: register result fields and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
            resp_cause <= CAUSE_NONE;
            resp_rw    <= 1'b0;
            resp_us    <= 1'b0;
        end else begin
            resp_valid <= ev_no_table || ev_leaf;
            if (ev_no_table) begin
                resp_paddr <= '0;
                resp_fault <= 1'b1;
                resp_cause <= CAUSE_NO_TABLE;
                resp_rw    <= 1'b0;
                resp_us    <= 1'b0;
            end else if (ev_leaf) begin
                if (!leaf_word[PRESENT_BIT]) begin
                    resp_paddr <= '0;
                    resp_fault <= 1'b1;
                    resp_cause <= CAUSE_NOT_PRESENT;
                    resp_rw    <= 1'b0;
                    resp_us    <= 1'b0;
                end else begin
                    resp_paddr <= {leaf_word[VA_W-1:OFF_BITS], offset};
                    resp_fault <= 1'b0;
                    resp_cause <= CAUSE_NONE;
                    resp_rw    <= leaf_word[RW_BIT];
                    resp_us    <= leaf_word[US_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Top: two-level page table walker. One request in flight; reads use a
// request/valid port with any latency; result is a one-cycle strobe.
module pt_walker #(
    parameter int VA_W        = 32,
    parameter int L1_BITS     = 10,
    parameter int L2_BITS     = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    input  logic [31:0]     root_base,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            resp_valid,
    output logic [31:0]     resp_paddr,
    output logic            resp_fault,
    output logic [1:0]      resp_cause,
    output logic            resp_rw,
    output logic            resp_us
);
    localparam int OFF_BITS = VA_W - L1_BITS - L2_BITS;

    logic                sel_l2;
    logic [VA_W-1:0]     vaddr_q;
    logic [VA_W-1:0]     root_q;
    logic [VA_W-1:0]     l1_q;
    logic                ev_no_table;
    logic                ev_leaf;
    logic [OFF_BITS-1:0] offset;

    pt_walk_ctrl #(.VA_W(VA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .root_base(root_base),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .req_ready(req_ready), .mem_req(mem_req), .sel_l2(sel_l2),
        .vaddr_q(vaddr_q), .root_q(root_q), .l1_q(l1_q),
        .ev_no_table(ev_no_table), .ev_leaf(ev_leaf)
    );

    pt_addr_gen #(
        .VA_W(VA_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_addr (
        .vaddr(vaddr_q), .root(root_q), .l1_word(l1_q), .sel_l2(sel_l2),
        .rd_addr(mem_addr), .offset(offset)
    );

    pt_resp_reg #(.VA_W(VA_W), .OFF_BITS(OFF_BITS)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .ev_no_table(ev_no_table), .ev_leaf(ev_leaf),
        .leaf_word(mem_rdata), .offset(offset),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_rw(resp_rw), .resp_us(resp_us)
    );
endmodule

// File: rtl/pt_walker_checker.sv
// Checker: port-level protocol properties of the walker, bound to the top.
module pt_walker_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [1:0]  resp_cause,
    input logic        resp_rw,
    input logic        resp_us
);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_with_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_clean_success_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_cause == 2'b00));

    assert_fault_no_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (!resp_rw && !resp_us && resp_cause != 2'b00));
endmodule

bind pt_walker pt_walker_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
    .resp_rw(resp_rw), .resp_us(resp_us)
);

// File: tb/pt_walker_test.sv
// Directed bench for the page table walker with a latency-configurable memory model.
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic [1:0]  resp_cause;
    logic        resp_rw;
    logic        resp_us;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int lat = 0;
    logic stray = 1'b0;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_rw(resp_rw), .resp_us(resp_us)
    );

    // Sparse memory contents: address/data pairs, unlisted words read 0.
    logic [31:0] tab_a [16];
    logic [31:0] tab_d [16];
    int          tab_n = 0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++) if (i < tab_n && tab_a[i] == a) r = tab_d[i];
        return r;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        tab_a[tab_n] = a;
        tab_d[tab_n] = d;
        tab_n++;
    endtask

    // Memory model: accepts a held request, answers after lat cycles.
    logic        m_rv = 1'b0;
    logic [31:0] m_data = '0;
    logic        pend = 1'b0;
    logic [31:0] pend_a = '0;
    int          cnt = 0;
    int          rd_total = 0;
    logic [31:0] rd_log [8];
    assign mem_rvalid = m_rv | stray;
    assign mem_rdata  = m_data;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (m_rv) begin
            m_rv <= 1'b0;
        end else if (pend) begin
            if (cnt == 0) begin
                m_rv   <= 1'b1;
                m_data <= lookup(pend_a);
                pend   <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_req && rst_n) begin
            pend   <= 1'b1;
            pend_a <= mem_addr;
            cnt    <= lat;
            rd_log[rd_total % 8] <= mem_addr;
            rd_total <= rd_total + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    task automatic wait_resp();
        int n = 0;
        while (!resp_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(resp_valid, "R9 result timeout", n, 500);
    endtask

    // Accept a request; optionally scramble inputs while the walk runs (R3).
    task automatic issue(input logic [31:0] va, input logic [31:0] root, input bit scramble);
        req_vaddr = va;
        root_base = root;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9 busy after accept", req_ready, 0);
        if (scramble) begin
            req_vaddr = 32'hDEAD_BEEF;
            root_base = 32'h0BAD_0000;
        end
        wait_resp();
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] pa, input bit rw, input bit us);
        check(resp_valid && !resp_fault && resp_cause == 2'b00, {tag, " R7 status"},
              {29'd0, resp_valid, resp_cause}, 32'h4);
        check(resp_paddr == pa, {tag, " R7 paddr"}, resp_paddr, pa);
        check(resp_rw == rw && resp_us == us, {tag, " R8 perms"},
              {30'd0, resp_rw, resp_us}, {30'd0, rw, us});
        check(req_ready, {tag, " R9 ready with result"}, req_ready, 1);
    endtask

    task automatic expect_fault(input string tag, input logic [1:0] cause);
        check(resp_valid && resp_fault && resp_cause == cause, {tag, " fault cause"},
              {29'd0, resp_fault, resp_cause}, {29'd0, 1'b1, cause});
        check(!resp_rw && !resp_us && resp_paddr == 0, {tag, " R8 zero on fault"},
              resp_paddr, 0);
    endtask

    task automatic test_basic();
        int base = rd_total;
        issue(32'h0040_3004, 32'h0008_0000, 1'b0);
        expect_ok("basic", 32'hABCD_E004, 1'b1, 1'b1);
        check(rd_log[base % 8] == 32'h0008_0004, "R2 first read addr", rd_log[base % 8], 32'h0008_0004);
        check(rd_log[(base + 1) % 8] == 32'h0010_000C, "R5 second read addr",
              rd_log[(base + 1) % 8], 32'h0010_000C);
        @(negedge clk);
        check(!resp_valid, "R9 single strobe", resp_valid, 0);
    endtask

    task automatic test_scramble();
        lat = 3;
        issue(32'h0040_3004, 32'h0008_0000, 1'b1);
        expect_ok("R3 inputs captured", 32'hABCD_E004, 1'b1, 1'b1);
        @(negedge clk);
    endtask

    task automatic test_not_present();
        lat = 1;
        issue(32'h0040_5008, 32'h0008_0000, 1'b0);
        expect_fault("R6 not present", 2'b10);
        @(negedge clk);
    endtask

    task automatic test_no_table();
        int base = rd_total;
        lat = 2;
        issue(32'h0080_3000, 32'h0008_0000, 1'b0);
        expect_fault("R4 no table", 2'b01);
        repeat (4) @(negedge clk);
        check(rd_total - base == 1, "R4 single read", rd_total - base, 1);
        check(rd_log[base % 8] == 32'h0008_0008, "R2 read addr idx2", rd_log[base % 8], 32'h0008_0008);
    endtask

    task automatic test_top_indices();
        int base = rd_total;
        lat = 5;
        issue(32'hFFFF_FFFF, 32'h0020_0000, 1'b0);
        expect_ok("R10 slow memory", 32'h0000_1FFF, 1'b1, 1'b0);
        check(rd_log[(base + 1) % 8] == 32'h0030_0FFC, "R5 max index addr",
              rd_log[(base + 1) % 8], 32'h0030_0FFC);
        @(negedge clk);
    endtask

    task automatic test_stray_valid();
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        check(!resp_valid && req_ready && !mem_req, "R11 stray valid ignored",
              {29'd0, resp_valid, req_ready, mem_req}, 32'h2);
        @(negedge clk);
        check(!resp_valid, "R11 no late result", resp_valid, 0);
        lat = 0;
        issue(32'h0040_3004, 32'h0008_0000, 1'b0);
        expect_ok("R11 next walk", 32'hABCD_E004, 1'b1, 1'b1);
        @(negedge clk);
    endtask

    // Result delivery and next acceptance in the same cycle (R9).
    task automatic test_back_to_back();
        lat = 1;
        req_vaddr = 32'h0040_3004;
        root_base = 32'h0008_0000;
        req_valid = 1'b1;
        @(negedge clk);
        check(!req_ready, "R9 busy", req_ready, 0);
        req_vaddr = 32'hFFFF_FFFF;
        root_base = 32'h0020_0000;
        wait_resp();
        expect_ok("R9 first of pair", 32'hABCD_E004, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && !resp_valid, "R9 second accepted at strobe",
              {30'd0, req_ready, resp_valid}, 0);
        wait_resp();
        expect_ok("R9 second of pair", 32'h0000_1FFF, 1'b1, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        put(32'h0008_0004, 32'h0010_0000);
        put(32'h0010_000C, 32'hABCD_E007);
        put(32'h0010_0014, 32'h1234_5006);
        put(32'h0020_0FFC, 32'h0030_0000);
        put(32'h0030_0FFC, 32'h0000_1003);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, "R1 reset state",
              {29'd0, req_ready, resp_valid, mem_req}, 32'h4);
        test_basic();
        test_scramble();
        test_not_present();
        test_no_table();
        test_top_indices();
        test_stray_valid();
        test_back_to_back();
        finish_run();
    end
endmodule